// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers eight interrupt request lines and gives each one a two-bit priority. It latches every request into a pending flag and offers the processor a single interrupt request line together with the index of the winning input. The winner is the pending input with the highest priority. Among inputs of equal priority, the lowest index wins. A request reaches the processor only if its priority is strictly above the level currently being serviced, so a higher-priority source can interrupt a handler while an equal or lower one waits.

When the processor acknowledges, the controller saves the level it was running at on a three-entry stack and takes on the priority of the acknowledged input. A return pulse restores the saved level. Software reaches the priority map, the stack depth and the pending flags through a small register bus with a single-cycle write strobe and a combinational read port. Writing the stack depth directly moves the controller to the level saved at that depth.

Internally a level is held in a 3-bit code: 0 means idle, which lies below every priority, and code p+1 stands for priority p.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0, irq_o is low and the controller is idle.
- R2: The priority register at address 0x2A is 16 bits read/write; input n's priority (0 lowest, 3 highest) sits in bits 2n+1:2n.
- R3: A high req_i[n] at a clock edge sets pending bit n, and the bit stays set after req_i[n] falls; pending bits read at address 0x2C bits 7:0, a write to 0x2C replaces them with wdata_i[7:0], and bits 15:8 read 0.
- R4: irq_o rises on the clock edge after the edge that records an eligible request; a request is eligible when its priority is strictly greater than the current level (idle counts as below 0).
- R5: Among eligible pending inputs, vec_o selects the highest priority, and on a tie the lowest index.
- R6: While irq_o is high and ack_i is low, irq_o stays high and vec_o stays unchanged; after an edge with irq_o and ack_i both high, irq_o is low for at least one cycle.
- R7: An acknowledge (ack_i high while irq_o is high) clears the pending bit of vec_o, pushes the current level, adds 1 to the stack count, and makes vec_o's priority the current level.
- R8: A ret_i pulse, when no acknowledge occurs in the same cycle, pops the top saved level into the current level and subtracts 1 from the stack count.
- R9: An acknowledge with a stack count of 3 leaves the count at 3, but still clears the pending bit and updates the current level; a ret_i with a count of 0 leaves the count at 0.
- R10: A write to address 0x2B sets the stack count to wdata_i[2:0], with any value above 3 taken as 3. It sets the current level to idle for a count of 0, and to the saved entry count-1 otherwise. Bits 15:3 read 0.
- R11: While an input is being serviced, a new request of equal or lower priority does not raise irq_o.
- R12: An ack_i while irq_o is low has no effect, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines |
| ack_i | input | 1 | Processor acknowledge |
| ret_i | input | 1 | Return-from-interrupt pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 3 | Index of the requesting input |

## Verification
Several rules are checked on every cycle by the assertions. An unacknowledged request must keep irq_o and vec_o steady, and irq_o must drop after an acknowledge. Recorded requests must show up in the pending flags, an acknowledge must clear its pending bit, and each push or pop must move the stack count by exactly one. Other behaviour depends on what the controller has seen before, and only the bench scenarios can show it. This covers the priority-then-index choice across several priority maps, the refusal of equal-priority requests during nesting, the restoring of levels across a three-deep nest, the behaviour of a direct write to the stack count, and the ignored push and pop at the stack limits.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter logic [7:0] PRIO_ADDR = 8'h2A,
  parameter logic [7:0] SP_ADDR   = 8'h2B,
  parameter logic [7:0] STAT_ADDR = 8'h2C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic        ack_i,
  input  logic        ret_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic [2:0]  vec_o
);

  logic [15:0] prio;
  logic [7:0]  pend;
  logic [1:0]  sp;
  logic [2:0]  cur;
  logic [2:0]  saved [3];
  logic [2:0]  win;
  logic [2:0]  best;
  logic        found;

  wire take    = irq_o & ack_i;
  wire back    = ret_i & ~take;
  wire prio_wr = we_i && addr_i == PRIO_ADDR;
  wire sp_wr   = we_i && addr_i == SP_ADDR;
  wire stat_wr = we_i && addr_i == STAT_ADDR;

  wire [1:0] sp_new   = (wdata_i[2:0] > 3'd3) ? 2'd3 : wdata_i[1:0];
  wire [2:0] take_lvl = {1'b0, prio[2*vec_o +: 2]} + 3'd1;
  wire [7:0] clr_mask = take ? (8'b1 << vec_o) : 8'b0;

  always_comb begin
    best  = cur;
    win   = 3'd0;
    found = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (pend[i] && ({1'b0, prio[2*i +: 2]} + 3'd1) > best) begin
        best  = {1'b0, prio[2*i +: 2]} + 3'd1;
        win   = 3'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      PRIO_ADDR: rdata_o = prio;
      SP_ADDR:   rdata_o = {14'd0, sp};
      STAT_ADDR: rdata_o = {8'd0, pend};
      default:   rdata_o = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio  <= '0;
      pend  <= '0;
      sp    <= '0;
      cur   <= '0;
      irq_o <= 1'b0;
      vec_o <= '0;
      for (int i = 0; i < 3; i++) saved[i] <= '0;
    end else begin
      if (prio_wr) prio <= wdata_i;
      pend <= (stat_wr ? wdata_i[7:0] : (pend & ~clr_mask)) | req_i;

      if (sp_wr) begin
        sp  <= sp_new;
        cur <= (sp_new == 2'd0) ? 3'd0 : saved[sp_new - 2'd1];
      end else if (take) begin
        if (sp != 2'd3) begin
          saved[sp] <= cur;
          sp        <= sp + 2'd1;
        end
        cur <= take_lvl;
      end else if (back && sp != 2'd0) begin
        cur <= saved[sp - 2'd1];
        sp  <= sp - 2'd1;
      end

      irq_o <= take ? 1'b0 : (irq_o | found);
      if (!irq_o || take) vec_o <= win;
    end
  end

endmodule

module irq_nest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] req_i,
  input logic       ack_i,
  input logic       ret_i,
  input logic       irq_o,
  input logic [2:0] vec_o,
  input logic [7:0] pend,
  input logic [1:0] sp,
  input logic       sp_wr,
  input logic       stat_wr
);

  // R6
  hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(vec_o));

  // R6
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i |=> !irq_o);

  // R3
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> (pend & $past(req_i)) == $past(req_i));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i && !stat_wr && !req_i[vec_o] |=> !pend[$past(vec_o)]);

  // R7
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i && !sp_wr && sp != 2'd3 |=> sp == $past(sp) + 2'd1);

  // R8
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !(irq_o && ack_i) && !sp_wr && sp != 2'd0 |=> sp == $past(sp) - 2'd1);

  // R12
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !irq_o && !ret_i && !sp_wr |=> $stable(sp));

endmodule

bind nest_irq_ctrl irq_nest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .ret_i(ret_i),
  .irq_o(irq_o), .vec_o(vec_o), .pend(pend), .sp(sp),
  .sp_wr(sp_wr), .stat_wr(stat_wr)
);

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_i = '0;
  logic        ack_i = 1'b0, ret_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  logic [2:0]  vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl dut (.*);

  // {priority map, pending pattern, expected vector}
  localparam logic [26:0] TBL [7] = '{
    {16'h0000, 8'h01, 3'd0},
    {16'h0000, 8'hFF, 3'd0},
    {16'h0C00, 8'hFF, 3'd5},
    {16'hAAAA, 8'h90, 3'd4},
    {16'h4040, 8'h88, 3'd3},
    {16'h3020, 8'h44, 3'd6},
    {16'h0009, 8'h03, 3'd1}
  };

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse(int n);
    req_i = 8'(1 << n); cyc(); req_i = '0;
  endtask

  task automatic ack(); ack_i = 1'b1; cyc(); ack_i = 1'b0; endtask
  task automatic ret(); ret_i = 1'b1; cyc(); ret_i = 1'b0; endtask

  task automatic clean();
    wr(8'h2C, 16'h0000);
    ack();
    wr(8'h2B, 16'h0000);
    cyc();
  endtask

  initial begin
    logic [15:0] d;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    rd(8'h2A, d); chk("R1 prio", d, 16'h0000);
    rd(8'h2B, d); chk("R1 sp", d, 16'h0000);
    rd(8'h2C, d); chk("R1 stat", d, 16'h0000);

    // R2
    wr(8'h2A, 16'hE41B);
    rd(8'h2A, d); chk("R2 readback", d, 16'hE41B);

    // R3 (and R12 unmapped read)
    wr(8'h2A, 16'h0000);
    req_i = 8'h24; cyc(); req_i = '0; cyc();
    rd(8'h2C, d); chk("R3 latched", d, 16'h0024);
    wr(8'h2C, 16'hFFFF);
    rd(8'h2C, d); chk("R3 reserved", d, 16'h00FF);
    rd(8'h10, d); chk("R12 unmapped", d, 16'h0000);
    clean();

    // R4 timing
    pulse(3);
    chk("R4 not yet", {15'd0, irq_o}, 16'd0);
    cyc();
    chk("R4 raised", {15'd0, irq_o}, 16'd1);
    chk("R4 vec", {13'd0, vec_o}, 16'd3);
    clean();

    // R5 table
    for (int k = 0; k < 7; k++) begin
      wr(8'h2A, TBL[k][26:11]);
      wr(8'h2C, {8'd0, TBL[k][10:3]});
      cyc();
      chk($sformatf("R5 irq entry %0d", k), {15'd0, irq_o}, 16'd1);
      chk($sformatf("R5 vec entry %0d", k), {13'd0, vec_o}, {13'd0, TBL[k][2:0]});
      clean();
    end

    // Nesting: in0=1 in1=2 in2=3 in3=1
    wr(8'h2A, 16'h0079);
    pulse(0); cyc();
    chk("R7 vec0", {12'd0, irq_o, vec_o}, 16'h0008);
    ack();
    rd(8'h2B, d); chk("R7 sp1", d, 16'd1);
    chk("R6 drop", {15'd0, irq_o}, 16'd0);
    pulse(3); cyc(); cyc();
    chk("R11 equal held off", {15'd0, irq_o}, 16'd0);
    pulse(1); cyc();
    chk("R11 higher vec1", {12'd0, irq_o, vec_o}, 16'h0009);
    ack();
    rd(8'h2B, d); chk("R7 sp2", d, 16'd2);
    pulse(2); cyc();
    chk("R5 vec2", {12'd0, irq_o, vec_o}, 16'h000A);
    ack();
    rd(8'h2B, d); chk("R7 sp3", d, 16'd3);
    rd(8'h2C, d); chk("R7 cleared", d, 16'h0008);
    ret(); cyc();
    rd(8'h2B, d); chk("R8 sp2", d, 16'd2);
    chk("R8 level2 blocks", {15'd0, irq_o}, 16'd0);
    ret(); cyc();
    rd(8'h2B, d); chk("R8 sp1", d, 16'd1);
    chk("R8 level1 blocks", {15'd0, irq_o}, 16'd0);
    ret(); cyc();
    rd(8'h2B, d); chk("R8 sp0", d, 16'd0);
    chk("R8 idle vec3", {12'd0, irq_o, vec_o}, 16'h000B);
    ack(); ret(); cyc();

    // R10 write clamps; level becomes saved entry 2 (priority 2)
    wr(8'h2B, 16'hFFFF);
    rd(8'h2B, d); chk("R10 clamp", d, 16'h0003);
    pulse(1); cyc(); cyc();
    chk("R10 restored level blocks", {15'd0, irq_o}, 16'd0);
    pulse(2); cyc();
    chk("R9 vec2", {12'd0, irq_o, vec_o}, 16'h000A);
    ack();
    rd(8'h2B, d); chk("R9 full push", d, 16'd3);
    rd(8'h2C, d); chk("R9 pend cleared", d, 16'h0002);
    wr(8'h2B, 16'h0000);
    cyc();
    chk("R10 idle vec1", {12'd0, irq_o, vec_o}, 16'h0009);
    wr(8'h2C, 16'h0000);
    ack();
    ret(); ret(); cyc();
    rd(8'h2B, d); chk("R9 empty pop", d, 16'd0);

    // R12 stray acknowledge
    ack(); cyc();
    rd(8'h2B, d); chk("R12 stray ack", d, 16'd0);
    chk("R12 irq low", {15'd0, irq_o}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule